// File: doc/BRIEF.md
# Tuner Synthesizer Write-Only I2C Register Interface

This block receives the programming stream for a tuner frequency synthesizer over a two-wire I2C bus. The bus is write-only: the block never returns data, and it only pulls SDA low to acknowledge. A fast system clock samples SCL and SDA. Each line is cleaned by a synchronizer and a majority filter, and the block then detects START and STOP, receives bytes MSB first and acknowledges them.

After a START, the first byte is compared with a fixed prefix and a 2-bit address-select input, so up to four synthesizers can share one bus. Every later byte in the transfer is classified by its leading bit. A byte with a leading 0 opens a divider pair that forms a 15-bit divide ratio. A byte with a leading 1 carries the 7-bit control word, and the byte after it carries the 5-bit port word. Each register updates as a whole only once its last byte is complete, so the synthesizer never sees half a ratio.

Top module: `tuner_i2c_regs`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START always begins a new address phase.
- R2: The first byte after a START is accepted only when it equals 1,1,0,0,0,a,b,0 (MSB first), where a is `addr_sel[1]` and b is `addr_sel[0]`. This gives 0xC2 for select 01, 0xC0 for 00, 0xC4 for 10 and 0xC6 for 11. After any other address byte, the bus is ignored until the next START or STOP.
- R3: After an accepted address byte, and after every data byte that follows it, `sda_pull` is high from the SCL fall after the 8th bit until the SCL fall after the 9th clock. At all other times it is low.
- R4: A data byte whose bit 7 is 0 is the upper divider byte, and its bits 6..0 are ratio bits 14..8. The next byte supplies ratio bits 7..0. `div_ratio` changes only when that second byte completes.
- R5: A data byte whose bit 7 is 1 loads its bits 6..0 into `ctrl_word` when it completes. Bit 6 is high pump current, 5 is divider test, 4 is pump off, 3 and 2 are the reference-ratio select, 1 is prescaler on and 0 is drive off. The byte right after it loads its bits 4..0 into `port_word`.
- R6: An upper divider byte that is not followed by its partner before STOP leaves `div_ratio` unchanged.
- R7: The control pair may come before or after the divider pair. A divider pair followed by a control byte alone, and a control byte alone, are also accepted.
- R8: An address byte with bit 0 set (a read request) is not acknowledged and changes nothing.
- R9: A repeated START discards any half-received pair and restarts address matching.
- R10: After reset, `div_ratio` is 256, `ctrl_word` and `port_word` are 0 and `sda_pull` is low.
- R11: A pulse of one system clock on SCL or SDA is filtered out. It neither adds a bit nor creates a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 2 | Address select: bit 1 is the first select bit, bit 0 the second |
| sda_pull | output | 1 | High drives SDA low (acknowledge) |
| div_ratio | output | 15 | Programmable divide ratio |
| ctrl_word | output | 7 | Control bits from the control byte |
| port_word | output | 5 | Switching port outputs |

## Verification
Each register output is due about eight system clocks after the 8th SCL rising edge of its last byte. That delay covers two synchronizer flops, the filter taps, the edge register, the byte strobe and the register update. The acknowledge drive follows the next filtered SCL fall with a similar delay. The bench holds every bus phase for 25 system clocks and reads the acknowledge in the middle of the 9th SCL high phase. It checks mid-transfer values only after a full acknowledge clock and final values one bus phase after STOP, so every sample falls well after the due cycle and before any later byte could move the value.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int BYTE_W   = 8;
  localparam int RATIO_W  = 15;
  localparam int CTRL_W   = 7;
  localparam int PORT_W   = 5;
  localparam int SEL_W    = 2;
  localparam int PREFIX_W = BYTE_W - SEL_W - 1;
  localparam int HI_W     = RATIO_W - BYTE_W;
  localparam logic [PREFIX_W-1:0] DEV_PREFIX = 5'b11000;

  typedef enum logic [1:0] {PH_IDLE, PH_RECV, PH_SKIP} bus_phase_t;
  typedef enum logic [1:0] {EXP_FIRST, EXP_DIV_LO, EXP_PORT} expect_t;
endpackage

// File: rtl/tuner_line_filter.sv
module tuner_line_filter #(
  parameter int LINES  = 2,
  parameter int STAGES = 2,
  parameter int TAPS   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] clean_o
);
  localparam int HALF = TAPS / 2;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sync_q;
    logic [TAPS-1:0]   tap_q;
    logic [$clog2(TAPS+1)-1:0] ones;

    always_comb begin
      ones = '0;
      for (int k = 0; k < TAPS; k++) ones = ones + tap_q[k];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q     <= '1;
        tap_q      <= '1;
        clean_o[g] <= 1'b1;
      end else begin
        sync_q     <= {sync_q[STAGES-2:0], raw_i[g]};
        tap_q      <= {tap_q[TAPS-2:0], sync_q[STAGES-1]};
        clean_o[g] <= (ones > HALF);
      end
    end
  end
endmodule

// File: rtl/tuner_bit_engine.sv
module tuner_bit_engine
  import tuner_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [SEL_W-1:0]  addr_sel,
  output logic              sda_pull,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_q,
  output logic              frame_clr
);
  logic scl_d, sda_d, first_byte, ack_pend;
  bus_phase_t phase;
  logic [3:0] bit_cnt;
  logic [BYTE_W-1:0] shreg, next_byte;
  logic start_c, stop_c, scl_rise, scl_fall, addr_hit;

  assign start_c   = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_c    = scl_f & scl_d & ~sda_d & sda_f;
  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign next_byte = {shreg[BYTE_W-2:0], sda_f};
  assign addr_hit  = (next_byte[BYTE_W-1:SEL_W+1] == DEV_PREFIX) &&
                     (next_byte[SEL_W:1] == addr_sel) && !next_byte[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d      <= 1'b1;
      sda_d      <= 1'b1;
      phase      <= PH_IDLE;
      first_byte <= 1'b0;
      ack_pend   <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_q     <= '0;
      byte_stb   <= 1'b0;
      frame_clr  <= 1'b0;
      sda_pull   <= 1'b0;
    end else begin
      scl_d     <= scl_f;
      sda_d     <= sda_f;
      byte_stb  <= 1'b0;
      frame_clr <= 1'b0;
      if (start_c) begin
        phase      <= PH_RECV;
        first_byte <= 1'b1;
        bit_cnt    <= '0;
        ack_pend   <= 1'b0;
        sda_pull   <= 1'b0;
        frame_clr  <= 1'b1;
      end else if (stop_c) begin
        phase     <= PH_IDLE;
        ack_pend  <= 1'b0;
        sda_pull  <= 1'b0;
        frame_clr <= 1'b1;
      end else if (phase == PH_RECV) begin
        if (scl_rise && bit_cnt < 4'd8) begin
          shreg   <= next_byte;
          bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt == 4'd7) begin
            if (first_byte) begin
              if (addr_hit) begin
                ack_pend   <= 1'b1;
                first_byte <= 1'b0;
              end else begin
                phase <= PH_SKIP;
              end
            end else begin
              byte_stb <= 1'b1;
              byte_q   <= next_byte;
              ack_pend <= 1'b1;
            end
          end
        end else if (scl_fall && bit_cnt == 4'd8) begin
          if (ack_pend) begin
            sda_pull <= 1'b1;
            ack_pend <= 1'b0;
          end else begin
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
  import tuner_i2c_pkg::*;
#(
  parameter int RATIO_RST = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               byte_stb,
  input  logic [BYTE_W-1:0]  byte_q,
  input  logic               frame_clr,
  output logic [RATIO_W-1:0] div_ratio,
  output logic [CTRL_W-1:0]  ctrl_word,
  output logic [PORT_W-1:0]  port_word
);
  expect_t nxt;
  logic [HI_W-1:0] hi_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_ratio <= RATIO_W'(RATIO_RST);
      ctrl_word <= '0;
      port_word <= '0;
      hi_hold   <= '0;
      nxt       <= EXP_FIRST;
    end else if (frame_clr) begin
      nxt <= EXP_FIRST;
    end else if (byte_stb) begin
      case (nxt)
        EXP_FIRST: begin
          if (!byte_q[BYTE_W-1]) begin
            hi_hold <= byte_q[HI_W-1:0];
            nxt     <= EXP_DIV_LO;
          end else begin
            ctrl_word <= byte_q[CTRL_W-1:0];
            nxt       <= EXP_PORT;
          end
        end
        EXP_DIV_LO: begin
          div_ratio <= {hi_hold, byte_q};
          nxt       <= EXP_FIRST;
        end
        EXP_PORT: begin
          port_word <= byte_q[PORT_W-1:0];
          nxt       <= EXP_FIRST;
        end
        default: nxt <= EXP_FIRST;
      endcase
    end
  end
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
  import tuner_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3,
  parameter int RATIO_RST   = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [SEL_W-1:0]   addr_sel,
  output logic               sda_pull,
  output logic [RATIO_W-1:0] div_ratio,
  output logic [CTRL_W-1:0]  ctrl_word,
  output logic [PORT_W-1:0]  port_word
);
  logic [1:0] clean;
  logic scl_f, sda_f, byte_stb, frame_clr;
  logic [BYTE_W-1:0] byte_q;

  tuner_line_filter #(.LINES(2), .STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_filt (
    .clk(clk), .rst(rst), .raw_i({scl_i, sda_i}), .clean_o(clean));

  assign scl_f = clean[1];
  assign sda_f = clean[0];

  tuner_bit_engine u_eng (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f), .addr_sel(addr_sel),
    .sda_pull(sda_pull), .byte_stb(byte_stb), .byte_q(byte_q), .frame_clr(frame_clr));

  tuner_reg_bank #(.RATIO_RST(RATIO_RST)) u_bank (
    .clk(clk), .rst(rst), .byte_stb(byte_stb), .byte_q(byte_q), .frame_clr(frame_clr),
    .div_ratio(div_ratio), .ctrl_word(ctrl_word), .port_word(port_word));
endmodule

// File: rtl/tuner_i2c_chk.sv
module tuner_i2c_chk
  import tuner_i2c_pkg::*;
#(
  parameter int RATIO_RST = 256
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_f,
  input logic               sda_pull,
  input logic               byte_stb,
  input logic [BYTE_W-1:0]  byte_q,
  input logic [RATIO_W-1:0] div_ratio,
  input logic [CTRL_W-1:0]  ctrl_word,
  input logic [PORT_W-1:0]  port_word
);
  assert_reset_state_R10: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (div_ratio == RATIO_W'(RATIO_RST) && ctrl_word == '0 &&
                              port_word == '0 && !sda_pull));

  assert_ratio_on_byte_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_ratio) |-> $past(byte_stb));

  assert_ctrl_on_flag_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_word) |-> ($past(byte_stb) && $past(byte_q[BYTE_W-1])));

  assert_port_on_byte_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(port_word) |-> $past(byte_stb));

  assert_pull_starts_low_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_f);

  assert_pull_held_high_R3: assert property (@(posedge clk) disable iff (rst)
    (scl_f && $past(scl_f) && $past(sda_pull)) |-> sda_pull);
endmodule

bind tuner_i2c_regs tuner_i2c_chk #(.RATIO_RST(RATIO_RST)) u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_f), .sda_pull(sda_pull), .byte_stb(byte_stb),
  .byte_q(byte_q), .div_ratio(div_ratio), .ctrl_word(ctrl_word), .port_word(port_word));

// File: tb/sim_tuner_i2c_regs.sv
`timescale 1ns/1ps
module sim_tuner_i2c_regs;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] addr_sel = 2'b01;
  logic sda_pull;
  logic [14:0] div_ratio;
  logic [6:0] ctrl_word;
  logic [4:0] port_word;
  logic bus_sda;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign bus_sda = m_sda & ~sda_pull;

  tuner_i2c_regs u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus_sda), .addr_sel(addr_sel),
    .sda_pull(sda_pull), .div_ratio(div_ratio), .ctrl_word(ctrl_word), .port_word(port_word));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, input bit glitch = 0);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq();
      if (glitch) begin
        m_scl = 1'b1; @(negedge clk); m_scl = 1'b0; @(negedge clk);
      end
      m_scl = 1'b1; wq();
      if (glitch && b[i]) begin
        m_sda = 1'b0; @(negedge clk); m_sda = 1'b1; @(negedge clk);
      end
      wq();
      m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    ack = !bus_sda;
    wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic t_reset();
    check(div_ratio == 15'd256, "R10 ratio", div_ratio, 256);
    check(ctrl_word == 7'd0 && port_word == 5'd0, "R10 ctrl/port", {ctrl_word, port_word}, 0);
    check(!sda_pull, "R10 pull", sda_pull, 0);
  endtask

  task automatic t_forward();
    bit a;
    bus_start();
    send_byte(8'hC2, a); check(a, "R1 R2 address ack", a, 1);
    send_byte(8'h12, a); check(a, "R3 data ack", a, 1);
    check(div_ratio == 15'd256, "R4 ratio held after upper byte", div_ratio, 256);
    send_byte(8'h34, a);
    check(div_ratio == 15'h1234, "R4 ratio", div_ratio, 'h1234);
    send_byte(8'hD5, a);
    check(ctrl_word == 7'h55, "R5 ctrl loads on own byte", ctrl_word, 'h55);
    check(port_word == 5'd0, "R5 port before second byte", port_word, 0);
    send_byte(8'hF3, a); check(a, "R3 last ack", a, 1);
    bus_stop(); wq();
    check(port_word == 5'h13, "R5 port", port_word, 'h13);
    check(!sda_pull, "R3 pull released", sda_pull, 0);
  endtask

  task automatic t_reverse();
    bit a;
    bus_start();
    send_byte(8'hC2, a);
    send_byte(8'h80, a); send_byte(8'h0A, a);
    send_byte(8'h05, a); send_byte(8'h67, a);
    bus_stop(); wq();
    check(ctrl_word == 7'h00 && port_word == 5'h0A, "R7 reverse ctrl/port", {ctrl_word, port_word}, 'h0A);
    check(div_ratio == 15'h0567, "R7 reverse ratio", div_ratio, 'h0567);
  endtask

  task automatic t_mismatch();
    bit a;
    bus_start();
    send_byte(8'hC4, a); check(!a, "R2 mismatch no ack", a, 0);
    send_byte(8'h01, a); check(!a, "R2 ignored byte no ack", a, 0);
    send_byte(8'h02, a);
    bus_stop(); wq();
    check(div_ratio == 15'h0567, "R2 ratio untouched", div_ratio, 'h0567);
  endtask

  task automatic t_addr_map();
    bit a;
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      bus_start();
      send_byte(8'hC0 | 8'(s << 1), a);
      check(a, $sformatf("R2 select %0d ack", s), a, 1);
      send_byte(8'h80 | 8'(s), a);
      bus_stop(); wq();
      check(ctrl_word == 7'(s), "R7 control byte alone", ctrl_word, s);
    end
    addr_sel = 2'b01;
  endtask

  task automatic t_read_bit();
    bit a;
    bus_start();
    send_byte(8'hC3, a); check(!a, "R8 read request no ack", a, 0);
    send_byte(8'hFF, a);
    bus_stop(); wq();
    check(ctrl_word == 7'd3, "R8 ctrl untouched", ctrl_word, 3);
  endtask

  task automatic t_partial();
    bit a;
    bus_start();
    send_byte(8'hC2, a); send_byte(8'h7F, a);
    bus_stop(); wq();
    check(div_ratio == 15'h0567, "R6 lone upper byte", div_ratio, 'h0567);
  endtask

  task automatic t_restart();
    bit a;
    bus_start();
    send_byte(8'hC2, a); send_byte(8'h7F, a);
    bus_start();
    send_byte(8'hC2, a); check(a, "R9 address after restart", a, 1);
    send_byte(8'h01, a); send_byte(8'h02, a);
    bus_stop(); wq();
    check(div_ratio == 15'h0102, "R9 restart discards pair", div_ratio, 'h0102);
  endtask

  task automatic t_div_cb1();
    bit a;
    bus_start();
    send_byte(8'hC2, a); send_byte(8'h7F, a); send_byte(8'hFF, a); send_byte(8'hAA, a);
    bus_stop(); wq();
    check(div_ratio == 15'h7FFF, "R4 max ratio", div_ratio, 'h7FFF);
    check(ctrl_word == 7'h2A, "R7 pair then control byte", ctrl_word, 'h2A);
  endtask

  task automatic t_glitch();
    bit a;
    bus_start();
    send_byte(8'hC2, a, 1); check(a, "R11 address with glitches", a, 1);
    send_byte(8'h81, a, 1); send_byte(8'h15, a, 1);
    bus_stop(); wq();
    check(ctrl_word == 7'h01, "R11 ctrl with glitches", ctrl_word, 1);
    check(port_word == 5'h15, "R11 port with glitches", port_word, 'h15);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_forward();
    t_reverse();
    t_mismatch();
    t_addr_map();
    t_read_bit();
    t_partial();
    t_restart();
    t_div_cb1();
    t_glitch();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule